// File: doc/BRIEF.md
# CAN Receive Frame Queue with Event Flags

This block holds CAN 2.0 frames that an upstream acceptance filter has already passed, in a short first-in first-out queue. Each frame is kept as a four-word, 32-bit image: a control/status word, an identifier word and two payload words. A host reads the oldest unread frame through a fixed four-word output window. It then releases that frame by writing one to the frames-available bit of the flag-clear input.

Three event flags report the state of the queue. The frames-available flag is high while any unread frame is held. The warning flag rises when the number of unread frames grows from four to five. The overflow flag records that a frame arrived while the queue was full; that frame is dropped. Each flag is cleared by writing one to its position in the flag-clear input. Clearing the frames-available flag is the pop operation.

Top module: `can_rx_queue`

## Requirements
- R1: After synchronous reset, all three flags are low and all four window words read zero.
- R2: The window shows the oldest accepted frame that has not been popped yet. Frames leave the queue in the order they arrived.
- R3: Window word 0 carries these fields: the timestamp in bits 15:0, the length code in bits 19:16 (codes above 8 are stored as 8), remote in bit 20, extended-format in bit 21 and substitute-remote in bit 22. Bits 31:23 read zero.
- R4: Window word 1 carries the identifier. For a standard frame (extended bit 0), the low 11 bits of `rx_id` sit in bits 28:18 and all other bits are zero. For an extended frame, the 29-bit identifier sits in bits 28:0. Bits 31:29 are zero in both cases.
- R5: Payload byte k is `rx_data[63-8k -: 8]`. Bytes 0 to 3 fill word 2 and bytes 4 to 7 fill word 3, each starting at bits 31:24 and going down in bit order. A remote frame stores zero in both payload words.
- R6: `flag_avail` is high exactly when at least one frame is queued. Writing `flag_clr[0]`=1 pops the head frame, and `flag_avail` stays or goes high on the next cycle if frames remain. A pop request on an empty queue has no effect.
- R7: `flag_warn` sets on the cycle in which the unread count goes from 4 to 5. It holds until `flag_clr[1]`=1 is written. A set in the same cycle wins over a clear.
- R8: A frame that arrives while 5 frames are held, with no pop in the same cycle, is dropped and sets `flag_ovf`. The queue contents do not change. `flag_ovf` holds until `flag_clr[2]`=1 is written.
- R9: A push and a pop in the same cycle both take effect and leave the count unchanged. On a full queue this accepts the new frame and raises no overflow.
- R10: While the queue is empty, all four window words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | An accepted frame is presented this cycle |
| rx_ide | input | 1 | Extended identifier format |
| rx_srr | input | 1 | Substitute remote request bit |
| rx_rtr | input | 1 | Remote frame |
| rx_dlc | input | 4 | Length code |
| rx_stamp | input | 16 | Receive timestamp |
| rx_id | input | 29 | Identifier (low 11 bits used for a standard frame) |
| rx_data | input | 64 | Payload, byte 0 in bits 63:56 |
| flag_clr | input | 3 | Write-one-to-clear: bit 0 available/pop, bit 1 warning, bit 2 overflow |
| win_w0 | output | 32 | Head frame control/status word |
| win_w1 | output | 32 | Head frame identifier word |
| win_w2 | output | 32 | Head frame payload bytes 0 to 3 |
| win_w3 | output | 32 | Head frame payload bytes 4 to 7 |
| flag_avail | output | 1 | Frames available |
| flag_warn | output | 1 | Almost-full warning |
| flag_ovf | output | 1 | Overflow |

## Verification
A new frame and a host pop can land on the same clock edge. The most delicate case is when the queue is full: there the overlap must be treated as an exchange and not as an overflow. The bench fills the queue to five frames and presents a frame together with a pop in one cycle. It also repeats the overlap on an empty queue followed by a single push. A scoreboard queue is updated with the same pop-then-push rule, and every frame drained afterwards must match it, with `flag_ovf` still low. A second overlap drives the warning set and its clear in the same cycle, and `flag_warn` is expected to stay high.

// File: rtl/can_rx_queue_pkg.sv
`timescale 1ns/1ps
package can_rx_queue_pkg;
  localparam int WORD_W  = 32;
  localparam int ID_W    = 29;
  localparam int STD_W   = 11;
  localparam int STAMP_W = 16;
  localparam int DLC_W   = 4;
  localparam int MAX_DLC = 8;
  localparam int DATA_W  = 64;

  typedef struct packed {
    logic [WORD_W-1:0] w3;
    logic [WORD_W-1:0] w2;
    logic [WORD_W-1:0] w1;
    logic [WORD_W-1:0] w0;
  } mb_image_t;

  // flag_clr bit positions
  localparam int CLR_AVAIL = 0;
  localparam int CLR_WARN  = 1;
  localparam int CLR_OVF   = 2;
endpackage

// File: rtl/can_rx_queue_pack.sv
`timescale 1ns/1ps
module can_rx_queue_pack
  import can_rx_queue_pkg::*;
(
  input  logic               ide,
  input  logic               srr,
  input  logic               rtr,
  input  logic [DLC_W-1:0]   dlc,
  input  logic [STAMP_W-1:0] stamp,
  input  logic [ID_W-1:0]    id,
  input  logic [DATA_W-1:0]  data,
  output mb_image_t          img
);
  logic [DLC_W-1:0] dlc_sat;

  always_comb begin
    dlc_sat = (dlc > DLC_W'(MAX_DLC)) ? DLC_W'(MAX_DLC) : dlc;
    img.w0  = {9'b0, srr, ide, rtr, dlc_sat, stamp};
    if (ide) img.w1 = {3'b0, id};
    else     img.w1 = {3'b0, id[STD_W-1:0], 18'b0};
    img.w2 = rtr ? '0 : data[DATA_W-1:WORD_W];
    img.w3 = rtr ? '0 : data[WORD_W-1:0];
  end
endmodule

// File: rtl/can_rx_queue_store.sv
`timescale 1ns/1ps
module can_rx_queue_store
  import can_rx_queue_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop_req,
  input  mb_image_t    img_in,
  output mb_image_t    head_img,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic [$clog2(DEPTH+1)-1:0] count_next,
  output logic         drop
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  mb_image_t      mem [DEPTH];
  logic [PW-1:0]  wr_ptr, rd_ptr, rd_next;
  logic           full, pop, acc;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    full       = (count == CW'(DEPTH));
    pop        = pop_req && (count != '0);
    acc        = push && (!full || pop);
    drop       = push && !acc;
    count_next = count + CW'(acc) - CW'(pop);
    rd_next    = pop ? bump(rd_ptr) : rd_ptr;
  end

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (acc) mem[wr_ptr] <= img_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (acc) wr_ptr <= bump(wr_ptr);
      rd_ptr <= rd_next;
      count  <= count_next;
    end
  end

  // registered output window, bypassing a frame written into an empty slot
  always_ff @(posedge clk) begin
    if (rst || count_next == '0) head_img <= '0;
    else if (acc && wr_ptr == rd_next) head_img <= img_in;
    else head_img <= mem[rd_next];
  end

  p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_full_swap_r9: assert property (@(posedge clk) disable iff (rst)
    (push && pop_req && count == CW'(DEPTH)) |=> (count == CW'(DEPTH)));
  p_empty_pop_r6: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push && count == '0) |=> (count == '0));
endmodule

// File: rtl/can_rx_queue_flags.sv
`timescale 1ns/1ps
module can_rx_queue_flags
  import can_rx_queue_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic [$clog2(DEPTH+1)-1:0] count_next,
  input  logic                       drop,
  input  logic [2:0]                 clr,
  output logic                       avail,
  output logic                       warn,
  output logic                       ovf
);
  localparam int CW = $clog2(DEPTH+1);

  always_ff @(posedge clk) begin
    if (rst) begin
      avail <= 1'b0;
      warn  <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      avail <= (count_next != '0);
      if (count == CW'(DEPTH-1) && count_next == CW'(DEPTH)) warn <= 1'b1;
      else if (clr[CLR_WARN]) warn <= 1'b0;
      if (drop) ovf <= 1'b1;
      else if (clr[CLR_OVF]) ovf <= 1'b0;
    end
  end

  p_avail_count_r6: assert property (@(posedge clk) disable iff (rst)
    avail == (count != '0));
  p_warn_edge_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(warn) |-> (count == CW'(DEPTH) && $past(count) == CW'(DEPTH-1)));
  p_ovf_on_drop_r8: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovf);
endmodule

// File: rtl/can_rx_queue.sv
`timescale 1ns/1ps
module can_rx_queue
  import can_rx_queue_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rx_valid,
  input  logic         rx_ide,
  input  logic         rx_srr,
  input  logic         rx_rtr,
  input  logic [3:0]   rx_dlc,
  input  logic [15:0]  rx_stamp,
  input  logic [28:0]  rx_id,
  input  logic [63:0]  rx_data,
  input  logic [2:0]   flag_clr,
  output logic [31:0]  win_w0,
  output logic [31:0]  win_w1,
  output logic [31:0]  win_w2,
  output logic [31:0]  win_w3,
  output logic         flag_avail,
  output logic         flag_warn,
  output logic         flag_ovf
);
  localparam int CW = $clog2(DEPTH+1);

  mb_image_t     img, head;
  logic [CW-1:0] count, count_next;
  logic          drop;

  can_rx_queue_pack u_pack (
    .ide(rx_ide), .srr(rx_srr), .rtr(rx_rtr), .dlc(rx_dlc),
    .stamp(rx_stamp), .id(rx_id), .data(rx_data), .img(img)
  );

  can_rx_queue_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push(rx_valid), .pop_req(flag_clr[CLR_AVAIL]),
    .img_in(img), .head_img(head), .count(count), .count_next(count_next),
    .drop(drop)
  );

  can_rx_queue_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst), .count(count), .count_next(count_next),
    .drop(drop), .clr(flag_clr), .avail(flag_avail), .warn(flag_warn),
    .ovf(flag_ovf)
  );

  assign win_w0 = head.w0;
  assign win_w1 = head.w1;
  assign win_w2 = head.w2;
  assign win_w3 = head.w3;

  p_empty_window_r10: assert property (@(posedge clk) disable iff (rst)
    !flag_avail |-> ({win_w3, win_w2, win_w1, win_w0} == '0));
endmodule

// File: tb/can_rx_queue_test.sv
`timescale 1ns/1ps
module can_rx_queue_test;
  typedef struct {
    logic        ide, srr, rtr;
    logic [3:0]  dlc;
    logic [15:0] ts;
    logic [28:0] id;
    logic [63:0] data;
  } frm_t;

  logic clk = 1'b0, rst = 1'b1;
  logic rx_valid = 0, rx_ide = 0, rx_srr = 0, rx_rtr = 0;
  logic [3:0] rx_dlc = 0;
  logic [15:0] rx_stamp = 0;
  logic [28:0] rx_id = 0;
  logic [63:0] rx_data = 0;
  logic [2:0] flag_clr = 0;
  logic [31:0] win_w0, win_w1, win_w2, win_w3;
  logic flag_avail, flag_warn, flag_ovf;

  int tests = 0, fails = 0;
  bit mon_on = 0, done = 0;
  logic [127:0] expq[$];
  logic m_warn = 0, m_ovf = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #4 clk = ~clk;

  can_rx_queue uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_ide(rx_ide),
    .rx_srr(rx_srr), .rx_rtr(rx_rtr), .rx_dlc(rx_dlc), .rx_stamp(rx_stamp),
    .rx_id(rx_id), .rx_data(rx_data), .flag_clr(flag_clr),
    .win_w0(win_w0), .win_w1(win_w1), .win_w2(win_w2), .win_w3(win_w3),
    .flag_avail(flag_avail), .flag_warn(flag_warn), .flag_ovf(flag_ovf)
  );

  function automatic logic [127:0] image(input frm_t f);
    logic [31:0] a, b, c, d;
    a = {9'b0, f.srr, f.ide, f.rtr, (f.dlc > 4'd8) ? 4'd8 : f.dlc, f.ts};
    b = f.ide ? {3'b0, f.id} : {3'b0, f.id[10:0], 18'b0};
    c = f.rtr ? 32'h0 : f.data[63:32];
    d = f.rtr ? 32'h0 : f.data[31:0];
    return {d, c, b, a};
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and advances the scoreboard model
  task automatic drive(input logic p, input frm_t f, input logic [2:0] c);
    int cnt, ncnt;
    bit pop, acc;
    @(negedge clk);
    rx_valid = p; rx_ide = f.ide; rx_srr = f.srr; rx_rtr = f.rtr;
    rx_dlc = f.dlc; rx_stamp = f.ts; rx_id = f.id; rx_data = f.data;
    flag_clr = c;
    cnt  = expq.size();
    pop  = c[0] && cnt > 0;
    acc  = p && (cnt < 5 || pop);
    ncnt = cnt + int'(acc) - int'(pop);
    if (cnt == 4 && ncnt == 5) m_warn = 1'b1;
    else if (c[1]) m_warn = 1'b0;
    if (p && !acc) m_ovf = 1'b1;
    else if (c[2]) m_ovf = 1'b0;
    if (pop) void'(expq.pop_front());
    if (acc) expq.push_back(image(f));
  endtask

  function automatic frm_t rnd_frame();
    frm_t f;
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    f.ide = lfsr[3]; f.srr = lfsr[7]; f.rtr = lfsr[11] & lfsr[12];
    f.dlc = lfsr[19:16]; f.ts = lfsr[31:16] ^ 16'h5A5A;
    f.id = {lfsr[28:0]} ^ 29'h0ABC_DEF;
    f.data = {lfsr, ~lfsr ^ 32'h1357_9BDF};
    return f;
  endfunction

  task automatic idle(input logic [2:0] c);
    frm_t z;
    z = '{default: '0};
    drive(1'b0, z, c);
  endtask

  task automatic settle();
    @(posedge clk); #2;
  endtask

  // monitor: compares the design with the scoreboard after every edge
  always begin
    @(posedge clk); #2;
    if (mon_on) begin
      check("R2 window", {win_w3, win_w2, win_w1, win_w0},
            (expq.size() != 0) ? expq[0] : 128'h0);
      check("R6 avail", {127'h0, flag_avail}, {127'h0, expq.size() != 0});
      check("R7 warn", {127'h0, flag_warn}, {127'h0, m_warn});
      check("R8 ovf", {127'h0, flag_ovf}, {127'h0, m_ovf});
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    frm_t fa, fb, fc;
    fa = '{ide:0, srr:0, rtr:0, dlc:4'd8, ts:16'h1234, id:29'h55, data:64'h0102030405060708};
    fb = '{ide:1, srr:1, rtr:0, dlc:4'd3, ts:16'hBEEF, id:29'h0F000F56, data:64'hA1B2C3D4E5F60718};
    fc = '{ide:0, srr:0, rtr:1, dlc:4'd12, ts:16'h0000, id:29'h1FFFF859, data:64'hFFFFFFFFFFFFFFFF};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    // R1 reset state
    check("R1 reset window", {win_w3, win_w2, win_w1, win_w0}, 128'h0);
    check("R1 reset flags", {125'h0, flag_avail, flag_warn, flag_ovf}, 128'h0);
    mon_on = 1;

    // R3 R4 R5 standard data frame, hand-derived words
    drive(1, fa, 3'b000); settle();
    check("R3 word0 std", {96'h0, win_w0}, {96'h0, 32'h00081234});
    check("R4 word1 std", {96'h0, win_w1}, {96'h0, 32'h01540000});
    check("R5 payload", {64'h0, win_w2, win_w3}, {64'h0, 64'h0102030405060708});
    // pop to empty: R10 window zero
    idle(3'b001); settle();
    check("R10 empty window", {win_w3, win_w2, win_w1, win_w0}, 128'h0);
    // R6 pop on empty has no effect
    idle(3'b001); settle();
    check("R6 empty pop avail", {127'h0, flag_avail}, 128'h0);

    // R2 order, R3/R4 extended, R5 remote with saturated length
    drive(1, fb, 3'b000);
    drive(1, fc, 3'b000); settle();
    check("R3 word0 ext", {96'h0, win_w0}, {96'h0, 32'h0063BEEF});
    check("R4 word1 ext", {96'h0, win_w1}, {96'h0, 32'h0F000F56});
    idle(3'b001); settle();
    check("R2 second frame", {96'h0, win_w1}, {96'h0, 32'h01640000});
    check("R5 remote zero", {64'h0, win_w2, win_w3}, 128'h0);
    check("R3 remote dlc sat", {96'h0, win_w0}, {96'h0, 32'h00180000});
    idle(3'b001);

    // R7 fill to five
    for (int i = 0; i < 5; i++) drive(1, rnd_frame(), 3'b000);
    settle();
    check("R7 warn at five", {127'h0, flag_warn}, {127'h0, 1'b1});
    idle(3'b010); settle();
    check("R7 warn cleared", {127'h0, flag_warn}, 128'h0);

    // R8 overflow drop
    drive(1, rnd_frame(), 3'b000); settle();
    check("R8 ovf set", {127'h0, flag_ovf}, {127'h0, 1'b1});
    idle(3'b000);
    idle(3'b100); settle();
    check("R8 ovf cleared", {127'h0, flag_ovf}, 128'h0);

    // R9 push and pop together on a full queue
    drive(1, rnd_frame(), 3'b001); settle();
    check("R9 no ovf on swap", {127'h0, flag_ovf}, 128'h0);
    check("R9 still full avail", {127'h0, flag_avail}, {127'h0, 1'b1});
    // R7 set wins over clear: drain one, refill with a clear
    idle(3'b001);
    drive(1, rnd_frame(), 3'b010); settle();
    check("R7 set beats clear", {127'h0, flag_warn}, {127'h0, 1'b1});
    for (int i = 0; i < 6; i++) idle(3'b011);

    // R9 push and pop together on an empty queue, then mixed traffic
    drive(1, rnd_frame(), 3'b001);
    drive(1, rnd_frame(), 3'b001);
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(lfsr[4] | lfsr[9], rnd_frame(), {lfsr[13] & lfsr[14], lfsr[20] & lfsr[2], lfsr[5]});
    end
    for (int i = 0; i < 7; i++) idle(3'b111);
    idle(3'b000);
    settle();
    mon_on = 0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule